// File: doc/BRIEF.md
# Dual-Synthesizer Serial Programming Port

This block receives write-only programming words for two frequency synthesizers over a three-wire serial link: a serial clock, a serial data line and a level-sensitive load strobe. Each word has 24 bits: an 8-bit address and a 16-bit payload. The bits shift in most significant first on rising serial-clock edges while the strobe is low. When the strobe goes high, a word of exactly 24 bits is decoded. Its payload fields then update the integer divider (N), the swallow counter (S) or the fractional counter (F) of one of the two synthesizers, or a chip-wide flag that selects the reference edge.

The three serial lines are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected in the system clock domain. The lines rest high when idle, so the synchronizers come out of reset high and no edge is seen at start-up. Each synthesizer has a ready flag. The flag rises once all three of that synthesizer's counters have been written, and it stays high until reset.

Top module: `synth_ctrl_port`

## Requirements
- R1: After a synchronous active-low reset, every N, S and F output, both ready flags and the edge-select output are 0.
- R2: Bits are sampled on rising edges of ser_clk while ser_en is low. The first bit taken is address bit 7 and the 24th is payload bit 0, so the word is address[7:0] followed by payload[15:0].
- R3: Address 0x01 loads payload[9:0] into the N value of synthesizer 1. Address 0x11 loads payload[9:0] into the N value of synthesizer 2.
- R4: Addresses 0x02 and 0x12 load payload[3:0] into the S value of synthesizer 1 and 2. Addresses 0x03 and 0x13 load payload[4:0] into their F value. Payload bits outside each field are ignored.
- R5: A write to address 0x12 also copies payload[15] to ref_rise_sel (1 selects the rising reference edge, 0 the falling edge). No other address changes ref_rise_sel.
- R6: A complete word with any address other than 0x01, 0x02, 0x03, 0x11, 0x12 or 0x13 changes no output.
- R7: Rising ser_clk edges while ser_en is high shift no bit and do not count toward the next word.
- R8: Each ser_en pulse restarts framing. If fewer or more than 24 bits arrived since ser_en last fell, the rise of ser_en loads nothing.
- R9: synN_ok goes high once N, S and F of that synthesizer have each been written at least once, and it stays high until reset.
- R10: With all serial inputs held at their idle high level after reset, nothing is loaded.
- R11: A load appears at the outputs on the third rising system-clock edge after ser_en rises at the pin. On the edge before that, the outputs still hold their old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous, idles high) |
| ser_data | input | 1 | Serial data, MSB first (idles high) |
| ser_en | input | 1 | Load strobe, active high, level sensitive |
| syn1_n | output | N_W | Synthesizer 1 N divider value |
| syn1_s | output | S_W | Synthesizer 1 S counter value |
| syn1_f | output | F_W | Synthesizer 1 F counter value |
| syn1_ok | output | 1 | Synthesizer 1 fully programmed |
| syn2_n | output | N_W | Synthesizer 2 N divider value |
| syn2_s | output | S_W | Synthesizer 2 S counter value |
| syn2_f | output | F_W | Synthesizer 2 F counter value |
| syn2_ok | output | 1 | Synthesizer 2 fully programmed |
| ref_rise_sel | output | 1 | 1: rising reference edge, 0: falling |

## Verification
A load lands three system-clock edges after ser_en rises at the pin: two synchronizer stages, then the register write. The driver notes the cycle in which it raises ser_en. It queues the unchanged state due two cycles later and the new state due three cycles later. The monitor compares the outputs only in the cycle each item is due, half a clock after the edge. Serial bits are held for several system clocks on each side of every ser_clk edge, so that synchronizer skew cannot move a sample.

// File: rtl/synctl_pkg.sv
// Shared constants for the serial synthesizer programming port.
// Assumes a fixed word of one address byte followed by a 16-bit payload.
package synctl_pkg;
    localparam int ADDR_BITS = 8;
    localparam int DATA_BITS = 16;
    localparam int WORD_BITS = ADDR_BITS + DATA_BITS;
    localparam int NUM_SYN   = 2;
    // Register offsets from a synthesizer base address.
    localparam int OFF_N = 1;
    localparam int OFF_S = 2;
    localparam int OFF_F = 3;
    // Payload bit that carries the reference-edge select.
    localparam int PS_BIT = 15;
    localparam int CNT_W = $clog2(WORD_BITS + 2);
endpackage

// File: rtl/synctl_sync.sv
// Two-stage synchronizer bank plus one delay stage for edge detection.
// Assumes inputs idle high, so every stage resets to 1 and no edge is
// produced when reset is released.
module synctl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic st1, st2, st3;
        // Resynchronize one line and keep a delayed copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1 <= 1'b1;
                st2 <= 1'b1;
                st3 <= 1'b1;
            end else begin
                st1 <= din[gi];
                st2 <= st1;
                st3 <= st2;
            end
        end
        assign q[gi]   = st2;
        assign q_d[gi] = st3;
    end
endmodule

// File: rtl/synctl_shifter.sv
// Serial-to-parallel word assembler with exact-length framing.
// Shifts on synchronized serial clock rises while the strobe is low,
// counts bits (saturating past the word length) and raises load_stb
// on the strobe rise only when exactly WORD_BITS bits arrived.
module synctl_shifter
    import synctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_rise,
    input  logic                 sdata,
    input  logic                 en_lvl,
    input  logic                 en_rise,
    output logic [WORD_BITS-1:0] word,
    output logic                 load_stb
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_BITS + 1);

    logic [WORD_BITS-1:0] sh_q;
    logic [CNT_W-1:0]     cnt_q;

    // Shift and count bits; the strobe level freezes the shifter and clears framing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en_lvl) begin
            cnt_q <= '0;
        end else if (sck_rise) begin
            sh_q  <= {sh_q[WORD_BITS-2:0], sdata};
            cnt_q <= (cnt_q == CNT_SAT) ? CNT_SAT : cnt_q + 1'b1;
        end
    end

    assign word     = sh_q;
    assign load_stb = en_rise && (cnt_q == CNT_FULL);

    // R7: the shift register does not move while the strobe is high.
    a_r7_hold_while_en: assert property (@(posedge clk) disable iff (!rst_n)
        en_lvl |=> $stable(sh_q));
    // R8: framing restarts on every strobe pulse.
    a_r8_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (cnt_q == '0));
    // R8: a load is only issued on a strobe rise.
    a_r8_load_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> (en_lvl && en_rise));
endmodule

// File: rtl/synctl_regfile.sv
// Address decode and counter registers for NUM_SYN synthesizers plus the
// shared reference-edge select. Assumes load_stb is a one-cycle pulse
// with a stable word. Unknown addresses leave every register untouched.
module synctl_regfile
    import synctl_pkg::*;
#(
    parameter int              N_W   = 10,
    parameter int              S_W   = 4,
    parameter int              F_W   = 5,
    parameter logic [ADDR_BITS-1:0] BASE1 = 8'h00,
    parameter logic [ADDR_BITS-1:0] BASE2 = 8'h10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load_stb,
    input  logic [WORD_BITS-1:0]           word,
    output logic [NUM_SYN-1:0][N_W-1:0]    n_o,
    output logic [NUM_SYN-1:0][S_W-1:0]    s_o,
    output logic [NUM_SYN-1:0][F_W-1:0]    f_o,
    output logic [NUM_SYN-1:0]             ok_o,
    output logic                           ps_o
);
    localparam logic [ADDR_BITS-1:0] PS_ADDR = ADDR_BITS'(BASE2 + OFF_S);

    logic [ADDR_BITS-1:0] addr;
    logic [DATA_BITS-1:0] data;
    logic [NUM_SYN-1:0]   hit;
    logic                 ps_hit;
    logic                 ps_q;

    assign addr = word[WORD_BITS-1:DATA_BITS];
    assign data = word[DATA_BITS-1:0];

    for (genvar gi = 0; gi < NUM_SYN; gi++) begin : g_syn
        localparam logic [ADDR_BITS-1:0] BASE = (gi == 0) ? BASE1 : BASE2;
        logic           hit_n, hit_s, hit_f;
        logic [N_W-1:0] n_q;
        logic [S_W-1:0] s_q;
        logic [F_W-1:0] f_q;
        logic [2:0]     wr_q;

        assign hit_n = load_stb && (addr == ADDR_BITS'(BASE + OFF_N));
        assign hit_s = load_stb && (addr == ADDR_BITS'(BASE + OFF_S));
        assign hit_f = load_stb && (addr == ADDR_BITS'(BASE + OFF_F));
        assign hit[gi] = hit_n | hit_s | hit_f;

        // Load the addressed counter field and note that it was written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                n_q  <= '0;
                s_q  <= '0;
                f_q  <= '0;
                wr_q <= '0;
            end else begin
                if (hit_n) begin
                    n_q     <= data[N_W-1:0];
                    wr_q[0] <= 1'b1;
                end
                if (hit_s) begin
                    s_q     <= data[S_W-1:0];
                    wr_q[1] <= 1'b1;
                end
                if (hit_f) begin
                    f_q     <= data[F_W-1:0];
                    wr_q[2] <= 1'b1;
                end
            end
        end

        assign n_o[gi]  = n_q;
        assign s_o[gi]  = s_q;
        assign f_o[gi]  = f_q;
        assign ok_o[gi] = &wr_q;

        // R9: a ready flag never drops outside reset.
        a_r9_ok_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            ok_o[gi] |=> ok_o[gi]);
    end

    assign ps_hit = load_stb && (addr == PS_ADDR);

    // Capture the reference-edge select from its host word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ps_q <= 1'b0;
        else if (ps_hit) ps_q <= data[PS_BIT];
    end
    assign ps_o = ps_q;

    // R6: a reserved address changes nothing.
    a_r6_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && (hit == '0)) |=>
            ($stable(n_o) && $stable(s_o) && $stable(f_o) && $stable(ps_o)));
    // R5: the edge select follows payload bit 15 of its host word.
    a_r5_ps_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ps_hit |=> (ps_o == $past(data[PS_BIT])));
    // R5: no other load moves the edge select.
    a_r5_ps_other: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_hit |=> $stable(ps_o));
endmodule

// File: rtl/synth_ctrl_port.sv
// Top level of the serial programming port for two synthesizers.
// Synchronizes the three serial lines, assembles 24-bit words and
// commits them to the counter registers on the strobe rise.
module synth_ctrl_port
    import synctl_pkg::*;
#(
    parameter int N_W = 10,
    parameter int S_W = 4,
    parameter int F_W = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_en,
    output logic [N_W-1:0] syn1_n,
    output logic [S_W-1:0] syn1_s,
    output logic [F_W-1:0] syn1_f,
    output logic           syn1_ok,
    output logic [N_W-1:0] syn2_n,
    output logic [S_W-1:0] syn2_s,
    output logic [F_W-1:0] syn2_f,
    output logic           syn2_ok,
    output logic           ref_rise_sel
);
    logic [2:0]                     sy_q, sy_d;
    logic                           sck_rise, en_rise;
    logic [WORD_BITS-1:0]           word;
    logic                           load_stb;
    logic [NUM_SYN-1:0][N_W-1:0]    n_v;
    logic [NUM_SYN-1:0][S_W-1:0]    s_v;
    logic [NUM_SYN-1:0][F_W-1:0]    f_v;
    logic [NUM_SYN-1:0]             ok_v;

    synctl_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_en, ser_data, ser_clk}),
        .q     (sy_q),
        .q_d   (sy_d)
    );

    assign sck_rise = sy_q[0] & ~sy_d[0];
    assign en_rise  = sy_q[2] & ~sy_d[2];

    synctl_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sdata    (sy_q[1]),
        .en_lvl   (sy_q[2]),
        .en_rise  (en_rise),
        .word     (word),
        .load_stb (load_stb)
    );

    synctl_regfile #(.N_W(N_W), .S_W(S_W), .F_W(F_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .word     (word),
        .n_o      (n_v),
        .s_o      (s_v),
        .f_o      (f_v),
        .ok_o     (ok_v),
        .ps_o     (ref_rise_sel)
    );

    assign syn1_n  = n_v[0];
    assign syn1_s  = s_v[0];
    assign syn1_f  = f_v[0];
    assign syn1_ok = ok_v[0];
    assign syn2_n  = n_v[1];
    assign syn2_s  = s_v[1];
    assign syn2_f  = f_v[1];
    assign syn2_ok = ok_v[1];

    // R11: nothing is loaded unless the strobe rose at the pin two edges earlier.
    a_r11_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> ($past(ser_en, 2) && !$past(ser_en, 3)));
endmodule

// File: tb/synth_ctrl_port_tb.sv
`timescale 1ns/1ps
module synth_ctrl_port_tb;
    typedef struct {
        int         due;
        logic [9:0] n1, n2;
        logic [3:0] s1, s2;
        logic [4:0] f1, f2;
        logic       ok1, ok2, ps;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1, ser_data = 1'b1, ser_en = 1'b1;
    logic [9:0] syn1_n, syn2_n;
    logic [3:0] syn1_s, syn2_s;
    logic [4:0] syn1_f, syn2_f;
    logic syn1_ok, syn2_ok, ref_rise_sel;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    exp_t q[$];
    exp_t m;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    synth_ctrl_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_en(ser_en),
        .syn1_n(syn1_n), .syn1_s(syn1_s), .syn1_f(syn1_f), .syn1_ok(syn1_ok),
        .syn2_n(syn2_n), .syn2_s(syn2_s), .syn2_f(syn2_f), .syn2_ok(syn2_ok),
        .ref_rise_sel(ref_rise_sel)
    );

    // Model update from the requirements (R3, R4, R5, R6, R9).
    task automatic model_write(input logic [7:0] a, input logic [15:0] d);
        case (a)
            8'h01: begin m.n1 = d[9:0]; m.ok1 = 1'b0; end
            8'h02: m.s1 = d[3:0];
            8'h03: m.f1 = d[4:0];
            8'h11: m.n2 = d[9:0];
            8'h12: begin m.s2 = d[3:0]; m.ps = d[15]; end
            8'h13: m.f2 = d[4:0];
            default: ;
        endcase
    endtask

    logic [2:0] w1 = 3'b000, w2 = 3'b000;

    task automatic push(input int due, input string tag);
        exp_t e;
        e = m;
        e.ok1 = &w1;
        e.ok2 = &w2;
        e.due = due;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic ser_bit(input logic b);
        @(negedge clk); ser_data = b;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Drive one frame of nbits (MSB first) then pulse the strobe.
    task automatic send(input logic [24:0] val, input int nbits, input int glitches, input string tag);
        int c;
        @(negedge clk);
        ser_en = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) ser_bit(val[i]);
        ser_data = 1'b1;
        ser_en = 1'b1;
        c = cyc;
        push(c + 2, {"R11 hold before load / ", tag});
        if (nbits == 24) begin
            model_write(val[23:16], val[15:0]);
            case (val[23:16])
                8'h01: w1[0] = 1'b1; 8'h02: w1[1] = 1'b1; 8'h03: w1[2] = 1'b1;
                8'h11: w2[0] = 1'b1; 8'h12: w2[1] = 1'b1; 8'h13: w2[2] = 1'b1;
                default: ;
            endcase
        end
        push(c + 3, tag);
        repeat (6) @(negedge clk);
        for (int g = 0; g < glitches; g++) begin
            repeat (3) @(negedge clk); ser_clk = 1'b1;
            repeat (3) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    // Scoreboard monitor: compare each expected item in its due cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.due < cyc) begin
                fails++;
                $display("FAIL %s: item missed, actual cycle %0d expected %0d", e.tag, cyc, e.due);
            end else if ({syn1_n, syn1_s, syn1_f, syn1_ok, syn2_n, syn2_s, syn2_f, syn2_ok, ref_rise_sel} !==
                         {e.n1, e.s1, e.f1, e.ok1, e.n2, e.s2, e.f2, e.ok2, e.ps}) begin
                fails++;
                $display("FAIL %s: actual n1=%h s1=%h f1=%h ok1=%b n2=%h s2=%h f2=%h ok2=%b ps=%b expected n1=%h s1=%h f1=%h ok1=%b n2=%h s2=%h f2=%h ok2=%b ps=%b",
                         e.tag, syn1_n, syn1_s, syn1_f, syn1_ok, syn2_n, syn2_s, syn2_f, syn2_ok, ref_rise_sel,
                         e.n1, e.s1, e.f1, e.ok1, e.n2, e.s2, e.f2, e.ok2, e.ps);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m = '{default: '0, tag: ""};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        push(cyc + 1, "R1 reset state");
        // R10: idle-high lines, then a strobe toggle with no bits.
        push(cyc + 20, "R10 idle inputs load nothing");
        repeat (25) @(negedge clk);
        send(25'h0, 0, 0, "R10 empty frame discarded");
        send({1'b0, 8'h01, 16'h02A5}, 24, 0, "R2 R3 syn1 N");
        send({1'b0, 8'h02, 16'hFFFB}, 24, 0, "R4 syn1 S field, R5 ps untouched");
        send({1'b0, 8'h03, 16'h0011}, 24, 0, "R4 R9 syn1 F and ready");
        send({1'b0, 8'h11, 16'h13FF}, 24, 0, "R3 syn2 N");
        send({1'b0, 8'h12, 16'h8005}, 24, 0, "R5 syn2 S with rising edge select");
        send({1'b0, 8'h13, 16'h001F}, 24, 0, "R4 R9 syn2 F and ready");
        send({1'b0, 8'h04, 16'hFFFF}, 24, 0, "R6 reserved 0x04");
        send({1'b0, 8'h00, 16'hFFFF}, 24, 0, "R6 reserved 0x00");
        send({1'b0, 8'h21, 16'h0155}, 24, 0, "R6 reserved 0x21");
        send({2'b0, 8'h01, 15'h0155}, 23, 0, "R8 short frame discarded");
        send({1'b1, 8'h01, 16'h0155}, 25, 0, "R8 long frame discarded");
        send({1'b0, 8'h01, 16'h0133}, 24, 5, "R7 load with clocks during strobe");
        send({1'b0, 8'h02, 16'h0006}, 24, 0, "R7 next word after strobe clocks");
        send({1'b0, 8'h12, 16'h0003}, 24, 0, "R5 falling edge select");
        send({1'b0, 8'h13, 16'h7FEA}, 24, 0, "R2 R4 syn2 F alternating bits");
        repeat (20) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule